// File: doc/BRIEF.md
# Two-wire memory slave controller

This block is the slave end of a two-wire serial bus, placed in front of a small byte-addressed memory that behaves like nonvolatile storage. It brings SCL and SDA into the system clock domain and finds START and STOP conditions. It compares the 7-bit device address and answers it, then takes a 16-bit word address sent high byte first. Bytes written after that are gathered in a page buffer. They are copied into storage only when a well-formed STOP ends the transfer. Reads come out of a free-running address pointer, which the master can keep advancing by acknowledging each byte.

Every committed write starts a timed commit period. The memory array is modelled as plain registers, so the delay is simulated with a counter rather than being physical. While the commit runs, the block ignores the bus completely, its own address included. A master finds out that the write has finished by sending the address repeatedly until it is acknowledged. SDA is never driven high: the block only puts out a pull-low enable for an external open-drain pad.

Storage has two regions. The main array starts at address zero, holds `MEM_DEPTH` bytes and uses a page of `MAIN_PAGE` bytes. A control region of eight bytes starts at `CTRL_BASE` and has an eight-byte page.

Top module: `twi_mem_slave`

## Requirements
- R1: A device address byte whose upper seven bits equal `DEV_ADDR` is acknowledged, whatever its lowest bit (1 = read, 0 = write). Any other address gets no acknowledge.
- R2: A write is the device address with bit 0 = 0, then the word address high byte, then the low byte, then one or more data bytes, and each byte is acknowledged. A STOP that follows at least one complete, acknowledged data byte stores all of those data bytes.
- R3: A STOP that comes before the first complete data byte, or partway through any data byte, stores nothing and does not start a commit period. In that case the very next address is acknowledged.
- R4: From a committed STOP until `WR_CYCLES` system clocks have passed, SDA is never pulled low, so read and write addresses both go unacknowledged.
- R5: Once the commit period is over, the next device address is acknowledged, and at least `WR_CYCLES` clocks separate the commit from that acknowledge.
- R6: Reset clears the address pointer to 0, so a read straight after reset returns the byte at address 0. Memory contents survive reset.
- R7: After any transfer, the address pointer holds the last address accessed plus one, and a plain read (device address with bit 0 = 1) starts there.
- R8: Data bytes are shifted out MSB first. If the master acknowledges, the next byte follows from the incremented pointer. On a missing acknowledge, SDA is released and stays released through the STOP.
- R9: In the main array, write data that runs past the end of a `MAIN_PAGE` page wraps around to the start of the same page.
- R10: In the control region, write data wraps within its eight-byte page.
- R11: If the word address falls outside both regions, its low byte gets no acknowledge and nothing is stored.
- R12: Synchronous reset releases SDA and ends any commit period, so an address sent right after reset is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the open-drain data line low |

## Verification
The assertions check on every clock that SDA stays released whenever the commit timer runs, that each commit arms the timer and never starts while it is already running, and that a STOP always leaves the line released. They also check that the pointer comes out of reset at zero. The bench scenarios are what show the data path. They cover the acknowledge pattern of each byte, the stored contents after clean and aborted STOPs, page wrap in both regions, pointer continuation across transfers and the polling interval. A behavioural model predicts all of these, and the bench also compares its expected drive window against `sda_oe` on every clock.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int CTRL_PAGE = 8;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD
    } phase_e;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_MAIN,
        RG_CTRL
    } region_e;

    typedef struct packed {
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic region_e classify(logic [15:0] a, int main_depth, logic [15:0] ctrl_base);
        if (int'(a) < main_depth) return RG_MAIN;
        if (a >= ctrl_base && a < ctrl_base + 16'(CTRL_PAGE)) return RG_CTRL;
        return RG_NONE;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output twi_pkg::bus_ev_t ev
);
    logic [1:0] scl_s;
    logic [1:0] sda_s;
    logic       scl_q;
    logic       sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= 2'b11;
            sda_s <= 2'b11;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_s <= {scl_s[0], scl_in};
            sda_s <= {sda_s[0], sda_in};
            scl_q <= scl_s[1];
            sda_q <= sda_s[1];
        end
    end

    always_comb begin
        ev.sda   = sda_s[1];
        ev.rise  = scl_s[1] & ~scl_q;
        ev.fall  = ~scl_s[1] & scl_q;
        ev.start = scl_s[1] & scl_q & sda_q & ~sda_s[1];
        ev.stop  = scl_s[1] & scl_q & ~sda_q & sda_s[1];
    end
endmodule

// File: rtl/twi_commit_timer.sv
module twi_commit_timer #(
    parameter int CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)               left <= '0;
        else if (kick)         left <= CW'(CYCLES);
        else if (left != '0)   left <= left - 1'b1;
    end

    assign busy = (left != '0);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter logic [6:0]  DEV_ADDR  = 7'h50,
    parameter int          MEM_DEPTH = 256,
    parameter int          MAIN_PAGE = 16,
    parameter logic [15:0] CTRL_BASE = 16'h0800,
    parameter int          WR_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);
    import twi_pkg::*;

    localparam int PW    = $clog2(MAIN_PAGE);
    localparam int TOTAL = MEM_DEPTH + CTRL_PAGE;
    localparam int IW    = $clog2(TOTAL);

    bus_ev_t       ev;
    logic          busy;
    logic          commit;
    phase_e        ph;
    logic [3:0]    bitn;
    logic          ack_slot;
    logic          oe;
    logic [7:0]    shin;
    logic [7:0]    shout;
    logic          rw_bit;
    logic          m_ack;
    logic [7:0]    addr_hi;
    logic [15:0]   ptr;
    logic [15:0]   pbase;
    logic [PW-1:0] woff;
    logic [PW-1:0] woff_nx;
    region_e       wreg;
    region_e       lo_reg;
    region_e       rd_reg;
    logic [15:0]   a_full;
    logic [7:0]    rd_now;
    logic          got_data;
    logic [7:0]          pbuf [MAIN_PAGE];
    logic [MAIN_PAGE-1:0] pvld;
    logic [7:0]          mem  [TOTAL];

    function automatic logic [IW-1:0] mem_idx(logic [15:0] a);
        if (classify(a, MEM_DEPTH, CTRL_BASE) == RG_CTRL)
            return IW'(MEM_DEPTH) + IW'(a - CTRL_BASE);
        return IW'(a);
    endfunction

    twi_line_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    twi_commit_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .kick (commit),
        .busy (busy)
    );

    always_comb begin
        a_full  = {addr_hi, shin};
        lo_reg  = classify(a_full, MEM_DEPTH, CTRL_BASE);
        rd_reg  = classify(ptr, MEM_DEPTH, CTRL_BASE);
        rd_now  = (rd_reg == RG_NONE) ? 8'hFF : mem[mem_idx(ptr)];
        woff_nx = (woff + 1'b1) &
                  ((wreg == RG_CTRL) ? PW'(CTRL_PAGE - 1) : PW'(MAIN_PAGE - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            bitn     <= '0;
            ack_slot <= 1'b0;
            oe       <= 1'b0;
            shin     <= '0;
            shout    <= '0;
            rw_bit   <= 1'b0;
            m_ack    <= 1'b0;
            addr_hi  <= '0;
            ptr      <= '0;
            pbase    <= '0;
            woff     <= '0;
            wreg     <= RG_NONE;
            pvld     <= '0;
            got_data <= 1'b0;
            commit   <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (busy) begin
                ph       <= PH_IDLE;
                oe       <= 1'b0;
                bitn     <= '0;
                ack_slot <= 1'b0;
            end else if (ev.start) begin
                ph       <= PH_DEV;
                bitn     <= '0;
                ack_slot <= 1'b0;
                oe       <= 1'b0;
                got_data <= 1'b0;
                pvld     <= '0;
            end else if (ev.stop) begin
                if (ph == PH_WR && got_data && bitn <= 4'd1 && !ack_slot)
                    commit <= 1'b1;
                ph       <= PH_IDLE;
                oe       <= 1'b0;
                bitn     <= '0;
                ack_slot <= 1'b0;
            end else if (ph == PH_RD) begin
                if (ev.rise) begin
                    if (bitn < 4'd8) bitn <= bitn + 4'd1;
                    else if (bitn == 4'd8) begin
                        m_ack <= ~ev.sda;
                        bitn  <= 4'd9;
                    end
                end else if (ev.fall) begin
                    if (bitn >= 4'd1 && bitn <= 4'd7) begin
                        shout <= {shout[6:0], 1'b0};
                        oe    <= ~shout[6];
                    end else if (bitn == 4'd8) begin
                        oe <= 1'b0;
                    end else if (bitn == 4'd9) begin
                        if (m_ack) begin
                            shout <= rd_now;
                            oe    <= ~rd_now[7];
                            ptr   <= ptr + 16'd1;
                            bitn  <= '0;
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end
                end
            end else if (ph != PH_IDLE) begin
                if (ev.rise && bitn < 4'd8) begin
                    shin <= {shin[6:0], ev.sda};
                    bitn <= bitn + 4'd1;
                end else if (ev.fall && bitn == 4'd8 && !ack_slot) begin
                    case (ph)
                        PH_DEV: begin
                            if (shin[7:1] == DEV_ADDR) begin
                                oe       <= 1'b1;
                                ack_slot <= 1'b1;
                                rw_bit   <= shin[0];
                            end else begin
                                ph <= PH_IDLE;
                            end
                        end
                        PH_AHI: begin
                            addr_hi  <= shin;
                            oe       <= 1'b1;
                            ack_slot <= 1'b1;
                        end
                        PH_ALO: begin
                            if (lo_reg == RG_NONE) begin
                                ph <= PH_IDLE;
                            end else begin
                                oe       <= 1'b1;
                                ack_slot <= 1'b1;
                                ptr      <= a_full;
                                wreg     <= lo_reg;
                                if (lo_reg == RG_CTRL) begin
                                    pbase <= a_full & ~16'(CTRL_PAGE - 1);
                                    woff  <= PW'(a_full[2:0]);
                                end else begin
                                    pbase <= a_full & ~16'(MAIN_PAGE - 1);
                                    woff  <= a_full[PW-1:0];
                                end
                            end
                        end
                        PH_WR: begin
                            oe         <= 1'b1;
                            ack_slot   <= 1'b1;
                            pbuf[woff] <= shin;
                            pvld[woff] <= 1'b1;
                            woff       <= woff_nx;
                            ptr        <= pbase | 16'(woff_nx);
                        end
                        default: ;
                    endcase
                end else if (ev.fall && ack_slot) begin
                    oe       <= 1'b0;
                    ack_slot <= 1'b0;
                    bitn     <= '0;
                    case (ph)
                        PH_DEV: begin
                            if (rw_bit) begin
                                ph    <= PH_RD;
                                shout <= rd_now;
                                oe    <= ~rd_now[7];
                                ptr   <= ptr + 16'd1;
                            end else begin
                                ph <= PH_AHI;
                            end
                        end
                        PH_AHI:  ph <= PH_ALO;
                        PH_ALO:  ph <= PH_WR;
                        PH_WR:   got_data <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int i = 0; i < MAIN_PAGE; i++) begin
                if (pvld[i]) mem[mem_idx(pbase | 16'(i))] <= pbuf[i];
            end
        end
    end

    assign sda_oe = oe;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        sda_oe,
    input logic        busy,
    input logic        commit,
    input logic        stop_seen,
    input logic [15:0] ptr
);
    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst) busy |-> !sda_oe); // R4
    AST_COMMIT_ARMS_TIMER: assert property (@(posedge clk) disable iff (rst) commit |=> busy); // R2
    AST_COMMIT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst) commit |-> !busy); // R4
    AST_PTR_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> ptr == 16'd0); // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst) stop_seen |=> !sda_oe); // R8
endmodule

bind twi_mem_slave twi_mem_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .commit    (commit),
    .stop_seen (ev.stop),
    .ptr       (ptr)
);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;
    localparam int          Q      = 8;
    localparam int          WRC    = 1000;
    localparam logic [6:0]  DEV    = 7'h50;
    localparam int          MDEPTH = 256;
    localparam int          PAGE   = 16;
    localparam logic [15:0] CBASE  = 16'h0800;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int  cyc = 0;
    int  vectors = 0;
    int  miscompares = 0;
    int  busy_from = -100000;
    bit  may_drive = 1'b0;
    bit  done = 1'b0;
    int  ref_ptr = 0;
    logic [7:0] ref_mem [int];

    assign sda_line = sda_m & ~sda_oe;

    twi_mem_slave #(
        .DEV_ADDR (DEV), .MEM_DEPTH(MDEPTH), .MAIN_PAGE(PAGE),
        .CTRL_BASE(CBASE), .WR_CYCLES(WRC)
    ) dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && !done) begin
            vectors++;
            if (sda_oe && (!may_drive || (cyc > busy_from + 8 && cyc < busy_from + WRC - 8))) begin
                miscompares++;
                $display("FAIL R4 per-clock drive window at cycle %0d: actual sda_oe=1 expected=0", cyc);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        miscompares++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop(input bit commits);
        sda_m = 1'b0; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b1;
        if (commits) busy_from = cyc;
        qwait(); qwait();
        may_drive = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit hold, output bit ack);
        may_drive = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl = 1'b1;   qwait(); qwait();
            scl = 1'b0;
            if (i == 0) may_drive = 1'b1;
            qwait();
        end
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        ack = !sda_line;
        qwait();
        scl = 1'b0;   qwait();
        if (!hold) may_drive = 1'b0;
    endtask

    task automatic send_partial(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; qwait();
            scl = 1'b1;   qwait(); qwait();
            scl = 1'b0;   qwait();
        end
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        may_drive = 1'b1;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl = 1'b1; qwait();
            b[i] = sda_line;
            qwait();
            scl = 1'b0; qwait();
        end
        sda_m = mack ? 1'b0 : 1'b1; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
        sda_m = 1'b1;
        if (!mack) may_drive = 1'b0;
    endtask

    function automatic int pmask(int a);
        return (a < MDEPTH) ? PAGE - 1 : 7;
    endfunction

    task automatic write_txn(input string req, input int a, input int n,
                             input logic [7:0] d0, d1, d2, d3);
        logic [7:0] d [4];
        bit ack;
        int m;
        int base;
        d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
        m = pmask(a);
        base = a & ~m;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack); chk({req, " R1 dev ack"}, ack, 1);
        send_byte(a[15:8], 1'b0, ack);    chk({req, " R2 addr hi ack"}, ack, 1);
        send_byte(a[7:0], 1'b0, ack);     chk({req, " R2 addr lo ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b0, ack);   chk({req, " R2 data ack"}, ack, 1);
            ref_mem[base | ((a + k) & m)] = d[k];
        end
        bus_stop(1'b1);
        ref_ptr = base | ((a + n) & m);
    endtask

    task automatic poll_once(input bit rd, output bit ack);
        bus_start();
        send_byte({DEV, rd}, rd, ack);
        if (ack && rd) begin
            logic [7:0] junk;
            recv_byte(1'b0, junk);
            ref_ptr = ref_ptr + 1;
        end
        bus_stop(1'b0);
    endtask

    task automatic wait_ready(input string req);
        bit ack;
        int polls = 0;
        ack = 1'b0;
        while (!ack && polls < 12) begin
            poll_once(1'b0, ack);
            polls++;
        end
        chk({req, " ready within poll limit"}, ack, 1);
    endtask

    task automatic read_out(input string req, input int n);
        logic [7:0] b;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(req, b, ref_mem.exists(ref_ptr) ? ref_mem[ref_ptr] : 8'hFF);
            ref_ptr = ref_ptr + 1;
        end
    endtask

    task automatic cur_read(input string req, input int n);
        bit ack;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, ack); chk({req, " R1 read dev ack"}, ack, 1);
        read_out(req, n);
        bus_stop(1'b0);
        chk({req, " R8 released after stop"}, sda_oe, 0);
    endtask

    task automatic rand_read(input string req, input int a, input int n);
        bit ack;
        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack); chk({req, " R1 dev ack"}, ack, 1);
        send_byte(a[15:8], 1'b0, ack);    chk({req, " addr hi ack"}, ack, 1);
        send_byte(a[7:0], 1'b0, ack);     chk({req, " addr lo ack"}, ack, 1);
        ref_ptr = a;
        bus_start();
        send_byte({DEV, 1'b1}, 1'b1, ack); chk({req, " R1 read dev ack"}, ack, 1);
        read_out(req, n);
        bus_stop(1'b0);
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        ref_ptr = 0;
        busy_from = -100000;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        bit ack;
        int t0;
        int polls;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R12 sda released after reset", sda_oe, 0);

        write_txn("R2 page write", 16'h0000, 4, 8'h11, 8'h22, 8'h33, 8'h44);
        t0 = busy_from;
        poll_once(1'b1, ack); chk("R4 read address during commit", ack, 0);
        poll_once(1'b0, ack); chk("R4 write address during commit", ack, 0);
        polls = 0;
        ack = 1'b0;
        while (!ack && polls < 12) begin
            poll_once(1'b0, ack);
            polls++;
        end
        chk("R5 acknowledge returns", ack, 1);
        chk("R5 commit interval respected", (cyc - t0) >= WRC, 1);

        pulse_reset();
        cur_read("R6 read after reset from address 0 (R8 sequential)", 2);
        cur_read("R7 read continues at last plus one", 1);

        bus_start();
        send_byte({7'h51, 1'b0}, 1'b0, ack); chk("R1 foreign device address", ack, 0);
        bus_stop(1'b0);

        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h02, 1'b0, ack);
        send_partial(8'h99, 4);
        bus_stop(1'b0);
        poll_once(1'b0, ack); chk("R3 no commit after partial first byte", ack, 1);
        rand_read("R3 contents kept after partial first byte", 16'h0002, 1);

        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h00, 1'b0, ack);
        send_byte(8'h77, 1'b0, ack);
        send_partial(8'h55, 3);
        bus_stop(1'b0);
        poll_once(1'b0, ack); chk("R3 no commit after stop inside second byte", ack, 1);
        rand_read("R3 contents kept after stop inside byte", 16'h0000, 2);

        write_txn("R9 main wrap", 16'h001E, 4, 8'hA0, 8'hA1, 8'hA2, 8'hA3);
        wait_ready("R5");
        rand_read("R9 wrapped bytes at page start", 16'h0010, 2);
        rand_read("R9 bytes at page end", 16'h001E, 2);

        write_txn("R10 control wrap", 16'h0806, 3, 8'hC0, 8'hC1, 8'hC2, 8'h00);
        pulse_reset();
        chk("R12 sda released by reset", sda_oe, 0);
        poll_once(1'b0, ack); chk("R12 reset ends commit period", ack, 1);
        rand_read("R10 control page start", 16'h0800, 1);
        rand_read("R10 control page end", 16'h0806, 2);

        bus_start();
        send_byte({DEV, 1'b0}, 1'b0, ack);
        send_byte(8'h04, 1'b0, ack);      chk("R11 high byte acknowledged", ack, 1);
        send_byte(8'h00, 1'b0, ack);      chk("R11 unmapped address refused", ack, 0);
        bus_stop(1'b0);
        poll_once(1'b0, ack); chk("R11 no commit after refused address", ack, 1);

        finish_run();
    end
endmodule